// File: doc/BRIEF.md
# Age-Ordered Per-Class Issue Selector

This block sits between the point where instructions become ready to run and the functional units that run them. Ready instructions arrive one per cycle over a valid/ready stream. Each carries an age tag, an operation class and a destination physical register number. The block keeps a small ready list for each class: integer ALU, integer multiply, integer divide and float divide. Each cycle it offers the oldest entry of every class whose unit can take work, and it issues those offers in ascending age order, up to a runtime issue limit.

Each class drives one functional unit with a configured latency. A unit is either pipelined or unpipelined. A pipelined unit takes a new operation every cycle. An unpipelined unit refuses new work until its current operation is done. Every unit reports completion, together with the destination register, when its latency has elapsed. Because each class keeps its own list, a busy divider holds back only divide instructions. Younger work of other classes still issues.

A squash input carries an age boundary. It removes every queued entry younger than that boundary from all lists, and it cancels an unpipelined operation in flight that is younger than the boundary. A smaller age means an older instruction. The insert stream has no hold rule: the producer may drop or change a request that was not accepted. The issue and completion outputs are single-cycle pulses, and the receiver must take them when they appear.

Top module: `iss_sel`

## Requirements
- R1: `ins_ready` is high exactly when `sq_valid` is low and the list of class `ins_cls` holds fewer than DEPTH entries. An entry is stored when `ins_valid` and `ins_ready` are both high at a clock edge. Class codes are 0 integer ALU, 1 integer multiply, 2 integer divide and 3 float divide.
- R2: An entry accepted at a clock edge can issue at the earliest in the cycle that follows that edge.
- R3: Per class, only the entry with the smallest age in its list can issue, and a class issues at most one entry per cycle.
- R4: Issue slots fill from slot 0 upward with no gaps, and a higher slot always carries a larger age than the slot below it.
- R5: The number of valid issue slots never exceeds the smaller of `issue_limit` and ISSUE_W. A limit of 0 stops issue.
- R6: A class whose unit cannot accept work does not issue, and its entries stay queued. Other classes issue in age order as usual.
- R7: A pipelined unit accepts an operation in every cycle and never reports busy. It raises its `cmp_valid` bit with the issued destination exactly LAT cycles after the issue cycle.
- R8: An unpipelined unit issued in cycle t holds `unit_busy` high in cycles t+1 through t+LAT-1. It completes in cycle t+LAT and may accept new work in that cycle.
- R9: In a cycle with `sq_valid` high, nothing issues and nothing is accepted. Every queued entry whose age exceeds `sq_age` is removed at the edge that ends the cycle.
- R10: A squash cancels an in-flight unpipelined operation whose age exceeds `sq_age`: it never completes and its busy flag drops at the next cycle. Operations in pipelined units still complete.
- R11: After reset all lists are empty, every unit is idle, no issue or completion is signalled, and `ins_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_limit | input | LIM_W | Maximum number of issues this cycle, clamped to ISSUE_W |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request can be accepted |
| ins_cls | input | CLS_W | Operation class of the inserted entry |
| ins_age | input | AGE_W | Age tag of the inserted entry (smaller is older) |
| ins_dst | input | PREG_W | Destination physical register of the inserted entry |
| sq_valid | input | 1 | Squash request |
| sq_age | input | AGE_W | Squash boundary; strictly younger work is discarded |
| iss_valid | output | ISSUE_W | Per-slot issue valid |
| iss_cls | output | ISSUE_W*CLS_W | Per-slot class |
| iss_age | output | ISSUE_W*AGE_W | Per-slot age |
| iss_dst | output | ISSUE_W*PREG_W | Per-slot destination register |
| unit_busy | output | NCLS | Per-class unit cannot accept work |
| cmp_valid | output | NCLS | Per-class completion pulse |
| cmp_dst | output | NCLS*PREG_W | Per-class completing destination register |

## Verification
The assertions rely on two properties of the inputs. First, ages are unique among all entries that are queued or in flight. Second, age order is never broken by wraparound, so that a larger number always means a younger instruction. Under these conditions the issue slots can be checked for strict age order, and a unit's busy flag can be tied to an issue of its own class. The stimulus enforces this with a bitmap of ages already handed out, which it never reuses. When the age counter nears its top, the stimulus stops inserting, lets every list and unit drain, and then clears the bitmap before it starts again from small ages.

// File: rtl/iss_pkg.sv
`timescale 1ns/1ps
package iss_pkg;
  localparam int NCLS  = 4;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU  = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_DIV  = 2'd2,
    CLS_FDIV = 2'd3
  } op_cls_e;
endpackage

// File: rtl/iss_list.sv
`timescale 1ns/1ps
// Ready list for one class: unordered slots, oldest found by search.
module iss_list #(
  parameter int DEPTH  = 4,
  parameter int AGE_W  = 8,
  parameter int PREG_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [AGE_W-1:0]  push_age,
  input  logic [PREG_W-1:0] push_dst,
  input  logic              pop,
  input  logic              sq_valid,
  input  logic [AGE_W-1:0]  sq_age,
  output logic              not_full,
  output logic              has_entry,
  output logic [AGE_W-1:0]  old_age,
  output logic [PREG_W-1:0] old_dst
);
  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0][AGE_W-1:0]  age_q;
  logic [DEPTH-1:0][PREG_W-1:0] dst_q;
  logic [IDX_W-1:0]             old_idx, free_idx;
  logic                         found, found_free;

  always_comb begin
    found      = 1'b0;
    found_free = 1'b0;
    old_idx    = '0;
    free_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i] && (!found || age_q[i] < age_q[old_idx])) begin
        found   = 1'b1;
        old_idx = IDX_W'(i);
      end
      if (!vld[i] && !found_free) begin
        found_free = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign has_entry = found;
  assign not_full  = found_free;
  assign old_age   = age_q[old_idx];
  assign old_dst   = dst_q[old_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (sq_valid) begin
      for (int i = 0; i < DEPTH; i++)
        if (vld[i] && age_q[i] > sq_age) vld[i] <= 1'b0;
    end else begin
      if (pop) vld[old_idx] <= 1'b0;
      if (push) begin
        vld[free_idx]   <= 1'b1;
        age_q[free_idx] <= push_age;
        dst_q[free_idx] <= push_dst;
      end
    end
  end
endmodule

// File: rtl/iss_fu.sv
`timescale 1ns/1ps
// One functional unit: latency model, pipelined or blocking variant.
module iss_fu #(
  parameter int LAT    = 3,
  parameter bit PIPED  = 1'b1,
  parameter int AGE_W  = 8,
  parameter int PREG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AGE_W-1:0]  go_age,
  input  logic [PREG_W-1:0] go_dst,
  input  logic              sq_valid,
  input  logic [AGE_W-1:0]  sq_age,
  output logic              free,
  output logic              busy,
  output logic              done,
  output logic [PREG_W-1:0] done_dst
);
  if (PIPED) begin : g_pipe
    logic [LAT-1:0]             pv;
    logic [LAT-1:0][PREG_W-1:0] pd;
    logic                       unused_sq;
    assign unused_sq = ^{go_age, sq_valid, sq_age};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pv <= '0;
      end else begin
        pv[0] <= go;
        for (int k = 1; k < LAT; k++) pv[k] <= pv[k-1];
      end
      pd[0] <= go_dst;
      for (int k = 1; k < LAT; k++) pd[k] <= pd[k-1];
    end

    assign free     = 1'b1;
    assign busy     = 1'b0;
    assign done     = pv[LAT-1];
    assign done_dst = pd[LAT-1];
  end else begin : g_block
    localparam int CNT_W = $clog2(LAT + 1);
    logic [CNT_W-1:0]  cnt;
    logic [AGE_W-1:0]  own_age;
    logic [PREG_W-1:0] own_dst;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
      end else if (go) begin
        cnt     <= CNT_W'(LAT);
        own_age <= go_age;
        own_dst <= go_dst;
      end else if (sq_valid && cnt != '0 && own_age > sq_age) begin
        cnt <= '0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign done     = (cnt == CNT_W'(1));
    assign busy     = (cnt > CNT_W'(1));
    assign free     = !busy;
    assign done_dst = own_dst;
  end
endmodule

// File: rtl/iss_rank.sv
`timescale 1ns/1ps
// Orders candidate classes by oldest age and grants the first few.
module iss_rank #(
  parameter int NCLS    = 4,
  parameter int AGE_W   = 8,
  parameter int ISSUE_W = 2,
  parameter int LIM_W   = 2,
  localparam int RK_W   = $clog2(NCLS + 1)
) (
  input  logic [NCLS-1:0]            cand,
  input  logic [NCLS-1:0][AGE_W-1:0] key,
  input  logic [LIM_W-1:0]           limit,
  output logic [NCLS-1:0]            grant,
  output logic [NCLS-1:0][RK_W-1:0]  rank
);
  int lim_eff;
  assign lim_eff = (int'(limit) > ISSUE_W) ? ISSUE_W : int'(limit);

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      int r;
      r = 0;
      for (int d = 0; d < NCLS; d++)
        if (d != c && cand[d] &&
            (key[d] < key[c] || (key[d] == key[c] && d < c)))
          r++;
      rank[c]  = RK_W'(r);
      grant[c] = cand[c] && (r < lim_eff);
    end
  end
endmodule

// File: rtl/iss_sel.sv
`timescale 1ns/1ps
module iss_sel
  import iss_pkg::*;
#(
  parameter int ISSUE_W  = 2,
  parameter int DEPTH    = 4,
  parameter int AGE_W    = 8,
  parameter int PREG_W   = 6,
  parameter int LAT_ALU  = 1,
  parameter int LAT_MUL  = 3,
  parameter int LAT_DIV  = 4,
  parameter int LAT_FDIV = 6,
  parameter logic [NCLS-1:0] PIPE_MASK = 4'b0011,
  localparam int LIM_W = $clog2(ISSUE_W + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LIM_W-1:0]           issue_limit,
  input  logic                       ins_valid,
  output logic                       ins_ready,
  input  logic [CLS_W-1:0]           ins_cls,
  input  logic [AGE_W-1:0]           ins_age,
  input  logic [PREG_W-1:0]          ins_dst,
  input  logic                       sq_valid,
  input  logic [AGE_W-1:0]           sq_age,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*CLS_W-1:0]   iss_cls,
  output logic [ISSUE_W*AGE_W-1:0]   iss_age,
  output logic [ISSUE_W*PREG_W-1:0]  iss_dst,
  output logic [NCLS-1:0]            unit_busy,
  output logic [NCLS-1:0]            cmp_valid,
  output logic [NCLS*PREG_W-1:0]     cmp_dst
);
  localparam int RK_W = $clog2(NCLS + 1);

  function automatic int lat_of(int c);
    case (c)
      0:       return LAT_ALU;
      1:       return LAT_MUL;
      2:       return LAT_DIV;
      default: return LAT_FDIV;
    endcase
  endfunction

  op_cls_e                      in_cls;
  logic [NCLS-1:0]              nf, has, fu_free, cand, grant, push;
  logic [NCLS-1:0][AGE_W-1:0]   old_age;
  logic [NCLS-1:0][PREG_W-1:0]  old_dst;
  logic [NCLS-1:0][RK_W-1:0]    rank;

  assign in_cls    = op_cls_e'(ins_cls);
  assign ins_ready = !sq_valid && nf[ins_cls];

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    assign push[g] = ins_valid && ins_ready && (in_cls == op_cls_e'(g));
    assign cand[g] = has[g] && fu_free[g] && !sq_valid;

    iss_list #(.DEPTH(DEPTH), .AGE_W(AGE_W), .PREG_W(PREG_W)) u_list (
      .clk(clk), .rst_n(rst_n),
      .push(push[g]), .push_age(ins_age), .push_dst(ins_dst),
      .pop(grant[g]), .sq_valid(sq_valid), .sq_age(sq_age),
      .not_full(nf[g]), .has_entry(has[g]),
      .old_age(old_age[g]), .old_dst(old_dst[g])
    );

    iss_fu #(.LAT(lat_of(g)), .PIPED(PIPE_MASK[g]), .AGE_W(AGE_W),
             .PREG_W(PREG_W)) u_fu (
      .clk(clk), .rst_n(rst_n),
      .go(grant[g]), .go_age(old_age[g]), .go_dst(old_dst[g]),
      .sq_valid(sq_valid), .sq_age(sq_age),
      .free(fu_free[g]), .busy(unit_busy[g]),
      .done(cmp_valid[g]), .done_dst(cmp_dst[g*PREG_W +: PREG_W])
    );
  end

  iss_rank #(.NCLS(NCLS), .AGE_W(AGE_W), .ISSUE_W(ISSUE_W),
             .LIM_W(LIM_W)) u_rank (
    .cand(cand), .key(old_age), .limit(issue_limit),
    .grant(grant), .rank(rank)
  );

  always_comb begin
    iss_valid = '0;
    iss_cls   = '0;
    iss_age   = '0;
    iss_dst   = '0;
    for (int s = 0; s < ISSUE_W; s++)
      for (int c = 0; c < NCLS; c++)
        if (grant[c] && rank[c] == RK_W'(s)) begin
          iss_valid[s]                   = 1'b1;
          iss_cls[s*CLS_W +: CLS_W]      = CLS_W'(c);
          iss_age[s*AGE_W +: AGE_W]      = old_age[c];
          iss_dst[s*PREG_W +: PREG_W]    = old_dst[c];
        end
  end
endmodule

// File: rtl/iss_sel_chk.sv
`timescale 1ns/1ps
module iss_sel_chk
  import iss_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int AGE_W   = 8,
  localparam int LIM_W  = $clog2(ISSUE_W + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [LIM_W-1:0]         issue_limit,
  input logic                     ins_ready,
  input logic                     sq_valid,
  input logic [ISSUE_W-1:0]       iss_valid,
  input logic [ISSUE_W*CLS_W-1:0] iss_cls,
  input logic [ISSUE_W*AGE_W-1:0] iss_age,
  input logic [NCLS-1:0]          unit_busy
);
  int lim_eff;
  assign lim_eff = (int'(issue_limit) > ISSUE_W) ? ISSUE_W : int'(issue_limit);

  logic [NCLS-1:0] hit;
  logic            dup;
  always_comb begin
    hit = '0;
    dup = 1'b0;
    for (int s = 0; s < ISSUE_W; s++)
      if (iss_valid[s]) begin
        if (hit[iss_cls[s*CLS_W +: CLS_W]]) dup = 1'b1;
        hit[iss_cls[s*CLS_W +: CLS_W]] = 1'b1;
      end
  end

  AST_ISSUE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_valid) <= lim_eff); // R5
  AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid & (iss_valid + 1'b1)) == '0); // R4
  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> (iss_valid == '0 && !ins_ready)); // R9
  AST_ONE_PER_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    !dup); // R3

  for (genvar s = 1; s < ISSUE_W; s++) begin : g_ord
    AST_AGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[s] |-> iss_age[s*AGE_W +: AGE_W] > iss_age[(s-1)*AGE_W +: AGE_W]); // R4
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_unit
    AST_BUSY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      unit_busy[c] |-> !hit[c]); // R6
    AST_BUSY_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unit_busy[c]) |-> $past(hit[c])); // R8
  end
endmodule

bind iss_sel iss_sel_chk #(.ISSUE_W(ISSUE_W), .AGE_W(AGE_W)) u_chk (.*);

// File: tb/iss_sel_test.sv
`timescale 1ns/1ps
module iss_sel_test;
  localparam int IW = 2;
  localparam int NC = 4;
  localparam int DP = 4;
  localparam int LATS [NC] = '{1, 3, 4, 6};
  localparam bit PIPS [NC] = '{1'b1, 1'b1, 1'b0, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  issue_limit = 2'd2;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [1:0]  ins_cls = '0;
  logic [7:0]  ins_age = '0;
  logic [5:0]  ins_dst = '0;
  logic        sq_valid = 1'b0;
  logic [7:0]  sq_age = '0;
  logic [1:0]  iss_valid;
  logic [3:0]  iss_cls;
  logic [15:0] iss_age;
  logic [11:0] iss_dst;
  logic [3:0]  unit_busy, cmp_valid;
  logic [23:0] cmp_dst;

  always #10 clk = ~clk;

  iss_sel uut (.*);

  int checks = 0, fails = 0;
  bit done_run = 1'b0;

  // reference state
  int mcnt [NC];
  int ma [NC][DP];
  int md [NC][DP];
  int pv [NC][8];
  int pd [NC][8];
  int ucnt [NC], uage [NC], udst [NC];
  bit used [256];
  int nxt_age;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin
      mcnt[c] = 0; ucnt[c] = 0;
      for (int k = 0; k < 8; k++) pv[c][k] = 0;
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Drive one cycle, compare against the model, advance the model.
  task automatic step(input bit iv, input int icls, input int ia, input int idst,
                      input bit sv, input int sa, input int lim);
    int le, nv, sl;
    bit cand [NC];
    int key [NC], kix [NC], rk [NC];
    bit gr [NC];
    bit er;
    int slot_c [IW];
    int exp_busy, exp_cmp;
    ins_valid = iv; ins_cls = icls[1:0]; ins_age = ia[7:0]; ins_dst = idst[5:0];
    sq_valid = sv; sq_age = sa[7:0]; issue_limit = lim[1:0];
    #1;
    le = (lim > IW) ? IW : lim;
    for (int c = 0; c < NC; c++) begin
      cand[c] = (mcnt[c] > 0) && (PIPS[c] || ucnt[c] <= 1) && !sv;
      key[c] = 999; kix[c] = 0;
      for (int k = 0; k < mcnt[c]; k++)
        if (ma[c][k] < key[c]) begin key[c] = ma[c][k]; kix[c] = k; end
    end
    nv = 0;
    for (int s = 0; s < IW; s++) slot_c[s] = -1;
    for (int c = 0; c < NC; c++) begin
      rk[c] = 0;
      for (int d = 0; d < NC; d++) if (cand[d] && key[d] < key[c]) rk[c]++;
      gr[c] = cand[c] && rk[c] < le;
      if (gr[c]) begin slot_c[rk[c]] = c; nv++; end
    end
    er = !sv && (mcnt[icls] < DP);
    check(ins_ready == er, "R1", "ins_ready", int'(ins_ready), int'(er));
    check(iss_valid == 2'((1 << nv) - 1), "R4 R5", "iss_valid",
          int'(iss_valid), (1 << nv) - 1);
    if (sv) check(iss_valid == '0, "R9", "issue during squash", int'(iss_valid), 0);
    for (int s = 0; s < IW; s++)
      if (slot_c[s] >= 0 && iss_valid[s]) begin
        sl = slot_c[s];
        check(int'(iss_cls[s*2 +: 2]) == sl, "R3 R6", "iss_cls", int'(iss_cls[s*2 +: 2]), sl);
        check(int'(iss_age[s*8 +: 8]) == key[sl], "R2 R3", "iss_age",
              int'(iss_age[s*8 +: 8]), key[sl]);
        check(int'(iss_dst[s*6 +: 6]) == md[sl][kix[sl]], "R3", "iss_dst",
              int'(iss_dst[s*6 +: 6]), md[sl][kix[sl]]);
      end
    for (int c = 0; c < NC; c++) begin
      exp_busy = (!PIPS[c] && ucnt[c] > 1) ? 1 : 0;
      exp_cmp = PIPS[c] ? pv[c][LATS[c]-1] : ((ucnt[c] == 1) ? 1 : 0);
      check(int'(unit_busy[c]) == exp_busy, "R8 R7", "unit_busy", int'(unit_busy[c]), exp_busy);
      check(int'(cmp_valid[c]) == exp_cmp, "R7 R8 R10", "cmp_valid", int'(cmp_valid[c]), exp_cmp);
      if (exp_cmp == 1)
        check(int'(cmp_dst[c*6 +: 6]) == (PIPS[c] ? pd[c][LATS[c]-1] : udst[c]), "R7 R8",
              "cmp_dst", int'(cmp_dst[c*6 +: 6]), PIPS[c] ? pd[c][LATS[c]-1] : udst[c]);
    end
    // next state
    for (int c = 0; c < NC; c++) begin
      int ga, gd;
      ga = key[c]; gd = md[c][kix[c]];
      if (gr[c]) begin
        for (int k = kix[c]; k < mcnt[c] - 1; k++) begin
          ma[c][k] = ma[c][k+1]; md[c][k] = md[c][k+1];
        end
        mcnt[c]--;
      end
      if (PIPS[c]) begin
        for (int k = LATS[c] - 1; k > 0; k--) begin pv[c][k] = pv[c][k-1]; pd[c][k] = pd[c][k-1]; end
        pv[c][0] = gr[c] ? 1 : 0; pd[c][0] = gd;
      end else if (gr[c]) begin
        ucnt[c] = LATS[c]; uage[c] = ga; udst[c] = gd;
      end else if (sv && ucnt[c] != 0 && uage[c] > sa) begin
        ucnt[c] = 0;
      end else if (ucnt[c] != 0) begin
        ucnt[c]--;
      end
      if (sv) begin
        int w;
        w = 0;
        for (int k = 0; k < mcnt[c]; k++)
          if (ma[c][k] <= sa) begin ma[c][w] = ma[c][k]; md[c][w] = md[c][k]; w++; end
        mcnt[c] = w;
      end
    end
    if (iv && er) begin
      ma[icls][mcnt[icls]] = ia; md[icls][mcnt[icls]] = idst; mcnt[icls]++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int lim);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, lim);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    check(iss_valid == '0, "R11", "iss_valid after reset", int'(iss_valid), 0);
    check(unit_busy == '0, "R11", "unit_busy after reset", int'(unit_busy), 0);
    check(cmp_valid == '0, "R11", "cmp_valid after reset", int'(cmp_valid), 0);
    check(ins_ready == 1'b1, "R11", "ins_ready after reset", int'(ins_ready), 1);
    @(negedge clk);

    // blocking unit busy, younger classes overtake (R6, R8), out-of-order within class (R3)
    step(1, 3, 10, 1, 0, 0, 2);
    step(1, 3, 30, 2, 0, 0, 2);
    step(1, 3, 20, 3, 0, 0, 2);
    step(1, 0, 25, 4, 0, 0, 2);
    step(1, 1, 26, 5, 0, 0, 2);
    idle(20, 2);
    // limit 0 stalls issue, list fills and refuses the fifth (R1, R5)
    for (int i = 0; i < 5; i++) step(1, 2, 60 + i, 10 + i, 0, 0, 0);
    step(1, 0, 80, 20, 0, 0, 0);
    step(1, 1, 81, 21, 0, 0, 0);
    idle(2, 1);
    idle(30, 3);
    // squash cancels younger blocking op, keeps older queued work (R9, R10)
    step(1, 2, 100, 30, 0, 0, 2);
    step(1, 3, 90, 31, 0, 0, 2);
    step(1, 1, 101, 32, 0, 0, 2);
    step(1, 2, 102, 33, 0, 0, 2);
    step(1, 0, 103, 34, 1, 95, 2);
    idle(20, 2);

    // randomized traffic with unique ages
    for (int c = 0; c < 256; c++) used[c] = 1'b0;
    nxt_age = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit iv, sv;
      int a, sa, lim;
      if (nxt_age > 230) begin
        idle(30, 2);
        for (int c = 0; c < 256; c++) used[c] = 1'b0;
        nxt_age = 1;
      end
      iv = ($urandom % 4) != 0;
      a = nxt_age + int'($urandom % 6);
      if (a > 255 || used[a]) iv = 1'b0;
      if (iv) begin used[a] = 1'b1; nxt_age++; end
      sv = ($urandom % 20) == 0;
      sa = nxt_age - int'($urandom % 8);
      if (sa < 0) sa = 0;
      lim = (($urandom % 8) == 0) ? int'($urandom % 4) : 2;
      step(iv, int'($urandom % 4), a, int'($urandom % 64), sv, sa, lim);
    end
    idle(10, 2);
    finish_run();
  end
endmodule